// File: doc/BRIEF.md
# Left-Edge Register Allocator

The block takes a table of value lifetimes and assigns each value to a storage register so that no two values in one register are alive at the same time. Each value has a birth step and a death step. A value occupies its register from its birth up to its death. A later value may take over that register at the step where the earlier value dies.

Software fills the table through a write port, sets the number of values to use, and pulses start. The engine handles values in order of increasing birth step; values with equal birth step are taken in address order. It fills one register at a time. The first value placed in a register is the earliest value still unplaced. After that, the earliest value that is born no sooner than the death of the value placed last is added. When no such value remains, the engine opens the next register. It places one value per clock cycle.

When it finishes, done is held high. The register index of each value can then be read through a combinational read port, together with the total number of registers used. If a lifetime is malformed (its death step is not after its birth step), the value is flagged and left out of the allocation.

Top module: `lea_alloc`

## Requirements
- R1: After reset, busy_o, done_o and reg_count_o are all 0, and rd_asg_o is 0 at every address.
- R2: While busy_o is low, wr_en_i stores wr_birth_i and wr_death_i at wr_addr_i. A write issued while busy_o is high is ignored, and a later run sees the old entry.
- R3: A start_i pulse while busy_o is low captures num_vals_i, clears all prior results and raises busy_o. Only the entries at addresses below num_vals_i take part in the run. A start_i pulse while busy_o is high is ignored.
- R4: An entry in range whose death step is less than or equal to its birth step reads rd_err_o=1 and rd_asg_o=0. Entries out of range read rd_err_o=0 and rd_asg_o=0.
- R5: Valid entries are handled in order of increasing birth step, with equal birth steps taken in increasing address order. The first value in that order is placed in register 0.
- R6: Once a register is open, the next value it takes is the first unplaced value in that order whose birth step is greater than or equal to the death step of the value placed last in that register. Equality counts as fitting.
- R7: When no unplaced value fits the open register, register index reg_count_o is opened for the first unplaced value in order, and reg_count_o rises by one.
- R8: At done, reg_count_o equals the largest number of valid lifetimes [birth, death) that overlap at any single step, which is the minimum register count.
- R9: With k valid entries, done_o first reads 1 after k+1 rising edges following the edge that accepted start_i. busy_o is high in between. busy_o and done_o are never both high. done_o stays high until the next accepted start.
- R10: rd_reg_o, rd_asg_o and rd_err_o show the entry at rd_addr_i combinationally. rd_asg_o=1 marks an entry that has been given register rd_reg_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 4 | Table write address |
| wr_birth_i | input | 8 | Birth step to store |
| wr_death_i | input | 8 | Death step to store |
| num_vals_i | input | 5 | Number of entries used by the run, sampled at start |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Allocation in progress |
| done_o | output | 1 | Allocation finished, results valid |
| rd_addr_i | input | 4 | Result read address |
| rd_reg_o | output | 4 | Register index of the addressed entry |
| rd_asg_o | output | 1 | Addressed entry has been placed |
| rd_err_o | output | 1 | Addressed entry has a malformed lifetime |
| reg_count_o | output | 5 | Registers opened so far |

## Verification
A wrong fit mask or a wrong tie-break shows up as a wrong rd_reg_o on at least one entry. Such a run usually also gives a reg_count_o above the peak overlap, and both are visible as soon as done_o rises. If the remaining-entry bookkeeping goes wrong, an entry may be placed twice or never. That shows as a done_o rising earlier or later than k+1 cycles after start, or as an entry with rd_asg_o low. If write or start gating goes wrong during a run, the final table changes on a repeat run with no reload.

// File: rtl/lea_pkg.sv
package lea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lea_state_e;
endpackage

// File: rtl/lea_pick.sv
// Finds the masked entry with the lowest birth step, lowest index on ties.
module lea_pick #(
  parameter int N  = 16,
  parameter int TW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][TW-1:0] birth_i,
  input  logic [N-1:0]         mask_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  logic [TW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!found_o || birth_i[i] < best)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = birth_i[i];
      end
    end
  end
endmodule

// File: rtl/lea_table.sv
module lea_table #(
  parameter int N  = 16,
  parameter int TW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_addr_i,
  input  logic [TW-1:0]        wr_birth_i,
  input  logic [TW-1:0]        wr_death_i,
  input  logic                 clr_i,
  input  logic                 asg_en_i,
  input  logic [IW-1:0]        asg_idx_i,
  input  logic [IW-1:0]        asg_reg_i,
  output logic [N-1:0][TW-1:0] birth_o,
  output logic [N-1:0][TW-1:0] death_o,
  output logic [N-1:0]         bad_o,
  output logic [N-1:0]         asg_o,
  output logic [N-1:0][IW-1:0] reg_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        birth_o[g] <= '0;
        death_o[g] <= '0;
        bad_o[g]   <= 1'b1;
      end else if (wr_en_i && wr_addr_i == IW'(g)) begin
        birth_o[g] <= wr_birth_i;
        death_o[g] <= wr_death_i;
        bad_o[g]   <= (wr_death_i <= wr_birth_i);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        asg_o[g] <= 1'b0;
        reg_o[g] <= '0;
      end else if (clr_i) begin
        asg_o[g] <= 1'b0;
        reg_o[g] <= '0;
      end else if (asg_en_i && asg_idx_i == IW'(g)) begin
        asg_o[g] <= 1'b1;
        reg_o[g] <= asg_reg_i;
      end
    end
  end

  // R6
  asg_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asg_en_i && !clr_i |-> !asg_o[asg_idx_i]);

  // R4
  bad_never_asg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asg_en_i |-> !bad_o[asg_idx_i]);
endmodule

// File: rtl/lea_ctrl.sv
module lea_ctrl
  import lea_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic remain_i,
  output logic busy_o,
  output logic done_o,
  output logic clr_o
);
  lea_state_e st_q, st_d;

  assign busy_o = (st_q == ST_RUN);
  assign done_o = (st_q == ST_DONE);
  assign clr_o  = start_i && !busy_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start_i) st_d = ST_RUN;
      ST_RUN:           if (!remain_i) st_d = ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R9
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
endmodule

// File: rtl/lea_alloc.sv
module lea_alloc #(
  parameter int NUM_VALS = 16,
  parameter int TIME_W   = 8,
  localparam int IW = $clog2(NUM_VALS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_addr_i,
  input  logic [TIME_W-1:0] wr_birth_i,
  input  logic [TIME_W-1:0] wr_death_i,
  input  logic [IW:0]       num_vals_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [IW-1:0]     rd_addr_i,
  output logic [IW-1:0]     rd_reg_o,
  output logic              rd_asg_o,
  output logic              rd_err_o,
  output logic [IW:0]       reg_count_o
);
  logic [NUM_VALS-1:0][TIME_W-1:0] birth, death;
  logic [NUM_VALS-1:0][IW-1:0]     regs;
  logic [NUM_VALS-1:0]             bad, asg, in_rng, rem_m, fit_m;
  logic [IW:0]                     n_q, cnt_q, cnt_m1;
  logic [TIME_W-1:0]               last_q;
  logic                            clr, fit_f, rem_f, asg_en;
  logic [IW-1:0]                   fit_i, rem_i, asg_idx, asg_reg;

  assign cnt_m1 = cnt_q - 1'b1;

  always_comb begin
    for (int i = 0; i < NUM_VALS; i++) begin
      in_rng[i] = (IW+1)'(i) < n_q;
      rem_m[i]  = in_rng[i] && !bad[i] && !asg[i];
      fit_m[i]  = rem_m[i] && (cnt_q != '0) && (birth[i] >= last_q);
    end
  end

  lea_pick #(.N(NUM_VALS), .TW(TIME_W)) u_fit (
    .birth_i(birth), .mask_i(fit_m), .found_o(fit_f), .idx_o(fit_i));

  lea_pick #(.N(NUM_VALS), .TW(TIME_W)) u_rem (
    .birth_i(birth), .mask_i(rem_m), .found_o(rem_f), .idx_o(rem_i));

  lea_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .remain_i(rem_f),
    .busy_o, .done_o, .clr_o(clr));

  // fit to open register first, otherwise open a new one
  assign asg_en  = busy_o && rem_f;
  assign asg_idx = fit_f ? fit_i : rem_i;
  assign asg_reg = fit_f ? cnt_m1[IW-1:0] : cnt_q[IW-1:0];

  lea_table #(.N(NUM_VALS), .TW(TIME_W)) u_tab (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_i && !busy_o), .wr_addr_i, .wr_birth_i, .wr_death_i,
    .clr_i(clr), .asg_en_i(asg_en), .asg_idx_i(asg_idx), .asg_reg_i(asg_reg),
    .birth_o(birth), .death_o(death), .bad_o(bad), .asg_o(asg), .reg_o(regs));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (clr) begin
      n_q    <= num_vals_i;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (asg_en) begin
      last_q <= death[asg_idx];
      if (!fit_f) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reg_count_o = cnt_q;
  assign rd_reg_o    = regs[rd_addr_i];
  assign rd_asg_o    = asg[rd_addr_i];
  assign rd_err_o    = bad[rd_addr_i] && in_rng[rd_addr_i];

  // R3
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(n_q));

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (reg_count_o == $past(reg_count_o)) ||
               (reg_count_o == $past(reg_count_o) + 1'b1));

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_count_o <= n_q);

  // R5
  first_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> reg_count_o == '0);
endmodule

// File: tb/lea_alloc_tb.sv
module lea_alloc_tb;
  localparam int N = 16;

  logic       clk_i = 0, rst_ni = 0;
  logic       wr_en_i = 0, start_i = 0;
  logic [3:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_birth_i = 0, wr_death_i = 0;
  logic [4:0] num_vals_i = 0;
  logic       busy_o, done_o, rd_asg_o, rd_err_o;
  logic [3:0] rd_reg_o;
  logic [4:0] reg_count_o;

  int checks = 0, errors = 0;
  int mb[N], md[N];
  int exp_reg[N];
  bit exp_bad[N];
  int exp_cnt, exp_k, exp_peak;

  always #2 clk_i = ~clk_i;

  lea_alloc u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stable sort by birth, then left-edge sweep
  task automatic model(int n);
    int ord[N];
    bit done_m[N];
    int m, last, r, peak, c;
    m = 0;
    for (int i = 0; i < N; i++) begin
      exp_reg[i] = -1;
      done_m[i] = 0;
      exp_bad[i] = (i < n) && (md[i] <= mb[i]);
    end
    for (int i = 0; i < n; i++) begin
      if (!exp_bad[i]) begin
        int j;
        j = m;
        while (j > 0 && mb[ord[j-1]] > mb[i]) begin
          ord[j] = ord[j-1];
          j--;
        end
        ord[j] = i;
        m++;
      end
    end
    r = 0;
    for (int s = 0; s < m; s++) begin
      if (!done_m[ord[s]]) begin
        exp_reg[ord[s]] = r;
        done_m[ord[s]] = 1;
        last = md[ord[s]];
        for (int t = s + 1; t < m; t++) begin
          if (!done_m[ord[t]] && mb[ord[t]] >= last) begin
            exp_reg[ord[t]] = r;
            done_m[ord[t]] = 1;
            last = md[ord[t]];
          end
        end
        r++;
      end
    end
    exp_cnt = r;
    exp_k = m;
    peak = 0;
    for (int t = 0; t < 256; t++) begin
      c = 0;
      for (int i = 0; i < n; i++)
        if (!exp_bad[i] && mb[i] <= t && t < md[i]) c++;
      if (c > peak) peak = c;
    end
    exp_peak = peak;
  endtask

  task automatic load(int i, int b, int d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 4'(i); wr_birth_i = 8'(b); wr_death_i = 8'(d);
    mb[i] = b; md[i] = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic run(int n, bit disturb);
    int cyc;
    model(n);
    @(negedge clk_i);
    num_vals_i = 5'(n); start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk("R3 busy after start", int'(busy_o), 1);
    cyc = 0;
    while (!done_o && cyc < 200) begin
      if (disturb && cyc == 0 && busy_o) begin
        // R2, R3: write and start while busy must be ignored
        wr_en_i = 1; wr_addr_i = 0; wr_birth_i = 8'd200; wr_death_i = 8'd100;
        start_i = 1; num_vals_i = 5'd1;
      end
      @(negedge clk_i);
      wr_en_i = 0; start_i = 0;
      cyc++;
    end
    chk("R9 latency", cyc, exp_k + 1);
    chk("R9 busy low at done", int'(busy_o), 0);
    chk("R8 reg count", int'(reg_count_o), exp_cnt);
    chk("R8 peak overlap", int'(reg_count_o), exp_peak);
    for (int i = 0; i < N; i++) begin
      rd_addr_i = 4'(i);
      #1;
      chk("R4 err flag", int'(rd_err_o), int'(exp_bad[i]));
      chk("R10 assigned flag", int'(rd_asg_o), int'(exp_reg[i] >= 0));
      if (exp_reg[i] >= 0) chk("R5 R6 R7 register index", int'(rd_reg_o), exp_reg[i]);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < N; i++) begin mb[i] = 0; md[i] = 0; end
    #9;
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 count", int'(reg_count_o), 0);
    rd_addr_i = 4'd5; #1;
    chk("R1 asg", int'(rd_asg_o), 0);
    rst_ni = 1;

    // empty run
    run(0, 0);

    // R6 equality boundary: chain fits one register
    load(0, 0, 2); load(1, 2, 4); load(2, 4, 6);
    run(3, 0);
    chk("R6 chain single reg", int'(reg_count_o), 1);

    // R5 equal births keep address order
    for (int i = 0; i < 5; i++) load(i, 3, 9);
    run(5, 0);

    // R4 malformed entries, R7 reopen
    load(0, 5, 5); load(1, 9, 4); load(2, 1, 8); load(3, 2, 3); load(4, 3, 9);
    run(5, 0);
    rd_addr_i = 4'd7; #1;
    chk("R4 out of range err", int'(rd_err_o), 0);

    // lifetime table with several registers
    load(0, 0, 4); load(1, 1, 3); load(2, 3, 7); load(3, 4, 6); load(4, 6, 9);
    load(5, 7, 10); load(6, 2, 5); load(7, 8, 12);
    run(8, 0);
    // R2 R3 disturbed run, then rerun without reload
    run(8, 1);
    run(8, 0);

    // full table, all overlapping
    for (int i = 0; i < N; i++) load(i, i, 100);
    run(16, 0);

    // random tables
    for (int t = 0; t < 25; t++) begin
      int n;
      n = int'($urandom_range(16, 1));
      for (int i = 0; i < n; i++) begin
        int b, d;
        b = int'($urandom_range(40, 0));
        if ($urandom_range(9, 0) == 0) d = b - int'($urandom_range(b, 0));
        else d = b + int'($urandom_range(15, 1));
        load(i, b, d);
      end
      run(n, t % 5 == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule